// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of maskable sources and one source that cannot be masked, picks the most urgent one, and raises a single request line towards the processor. Each maskable source carries a software-chosen urgency level, low or high. Inside a level, a hardwired order decides which source wins. The unmaskable source sits on a third level above both. Requests are caught on their rising edge and held until they are granted, so a short pulse is not lost.

The controller keeps one in-service bit per level. A pending request is offered to the processor only when its level is strictly above the highest level now in service. When the processor acknowledges, the controller grants the winner and marks its level as in service. One cycle later it returns the winner's source index on a single-cycle valid strobe. There is no back-pressure: the processor asked for the index by acknowledging, so it must take the index on that cycle. An end-of-service pulse retires the highest in-service level, and the interrupted lower level becomes the active one again.

Source index 0 is the unmaskable source. Maskable source `k` (input bit `req_i[k]`) is index `k+1`. Configuration goes through a small write port. With `cfg_sel_i=0` the write loads the enable mask: bit `k` enables source `k`, and bit `N_MASK` is the global enable. With `cfg_sel_i=1` the write loads the level mask: bit `k` set places source `k` at the high level.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset nothing is pending, nothing is in service, every maskable source is disabled and at the low level, and `irq_o` and `vec_valid_o` are low.
- R2: A rising edge on `nmi_i` raises `irq_o` whatever the enable mask holds. When it is granted it returns index 0 and outranks every maskable source.
- R3: Among eligible sources at the same level, the source with the lower bit position in `req_i` wins.
- R4: An eligible source at the high level wins over any eligible source at the low level, whatever their bit positions.
- R5: While a level is in service, a pending request at that level or at a lower level keeps `irq_o` low. A request at a strictly higher level raises it.
- R6: An `eoi_i` pulse clears only the highest in-service bit. A request that was blocked by the level underneath stays blocked until that level is retired as well.
- R7: When `ack_i` is high while `irq_o` is high, `vec_valid_o` is high on the next cycle only. `vec_idx_o` then carries the winner's index, and the winner's pending flag is cleared.
- R8: A rising-edge pulse on a request input stays pending while service at a higher or equal level blocks it. It is offered once the block lifts.
- R9: A pending source whose enable bit is cleared, or any maskable source while the global enable is clear, takes no part in arbitration. It keeps its pending flag and is offered again once it is re-enabled.
- R10: `ack_i` while `irq_o` is low produces no vector and changes no in-service bit.
- R11: When `ack_i` and `eoi_i` are high in the same cycle, the end-of-service clears the highest bit that was set before the cycle, and the grant sets the winner's level bit.
- R12: A new rising edge on a source in the cycle its earlier request is granted leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MASK | Maskable request lines, edge captured |
| nmi_i | input | 1 | Unmaskable request line, edge captured |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the enable mask, 1 selects the level mask |
| cfg_data_i | input | N_MASK+1 | Write data; bit N_MASK is the global enable for the enable mask |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End of service for the highest active level |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Granted index valid, one cycle |
| vec_idx_o | output | IDX_W | Granted source index |

## Verification
Two functions can land in the same cycle, and the bench drives each pair on one clock edge. In the first pair, a grant and an end-of-service arrive together. A low-level service is retired while a high-level request is acknowledged. The bench then judges that only the high level is left in service: one more end-of-service must let a fresh low-level request through. In the second pair, a source's new rising edge coincides with the grant of its earlier request. The scoreboard expects that source to come back as a second vector after the service is retired.

// File: rtl/nic_pkg.sv
package nic_pkg;
  // Service levels, ordered by urgency
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_TOP  = 2'd2
  } lvl_e;

  localparam int N_LVL = 3;
endpackage

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] prev_q;

  for (genvar g = 0; g < W; g++) begin : g_src
    logic rise;
    assign rise = req_i[g] & ~prev_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q[g] <= 1'b0;
        pend_o[g] <= 1'b0;
      end else begin
        prev_q[g] <= req_i[g];
        // a fresh edge wins over a grant clearing the older one
        if (rise)          pend_o[g] <= 1'b1;
        else if (clr_i[g]) pend_o[g] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int N_MASK = 5,
  parameter int IDX_W  = 3
) (
  input  logic [N_MASK:0]  pend_i,   // bit 0 unmaskable
  input  logic [N_MASK:0]  elig_i,
  input  logic [N_MASK:0]  hi_i,
  input  logic             cur_vld_i,
  input  lvl_e             cur_lvl_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] win_idx_o,
  output lvl_e             win_lvl_o,
  output logic [N_MASK:0]  win_oh_o
);
  logic             hi_hit, lo_hit, win_vld;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    // descending walk: the last hit is the lowest position
    for (int i = N_MASK; i >= 1; i--) begin
      if (pend_i[i] && elig_i[i]) begin
        if (hi_i[i]) begin
          hi_hit = 1'b1;
          hi_idx = IDX_W'(i);
        end else begin
          lo_hit = 1'b1;
          lo_idx = IDX_W'(i);
        end
      end
    end
  end

  always_comb begin
    win_vld   = 1'b1;
    win_idx_o = '0;
    win_lvl_o = LVL_TOP;
    if (pend_i[0]) begin
      win_idx_o = '0;
      win_lvl_o = LVL_TOP;
    end else if (hi_hit) begin
      win_idx_o = hi_idx;
      win_lvl_o = LVL_HIGH;
    end else if (lo_hit) begin
      win_idx_o = lo_idx;
      win_lvl_o = LVL_LOW;
    end else begin
      win_vld   = 1'b0;
    end
  end

  always_comb begin
    win_oh_o = '0;
    for (int i = 0; i <= N_MASK; i++)
      if (win_vld && win_idx_o == IDX_W'(i)) win_oh_o[i] = 1'b1;
  end

  assign irq_o = win_vld && (!cur_vld_i || (win_lvl_o > cur_lvl_i));
endmodule

// File: rtl/nic_inservice.sv
module nic_inservice
  import nic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eoi_i,
  input  logic             set_i,
  input  lvl_e             set_lvl_i,
  output logic [N_LVL-1:0] isr_o,
  output logic             cur_vld_o,
  output lvl_e             cur_lvl_o
);
  logic [N_LVL-1:0] top_oh, set_oh;

  always_comb begin
    top_oh    = '0;
    cur_vld_o = 1'b0;
    cur_lvl_o = LVL_LOW;
    for (int i = 0; i < N_LVL; i++) begin
      if (isr_o[i]) begin
        top_oh    = '0;
        top_oh[i] = 1'b1;
        cur_vld_o = 1'b1;
        cur_lvl_o = lvl_e'(i);
      end
    end
  end

  always_comb begin
    set_oh = '0;
    if (set_i) set_oh[set_lvl_i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr_o <= '0;
    else        isr_o <= (isr_o & ~(eoi_i ? top_oh : '0)) | set_oh;
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int N_MASK = 5,
  parameter int IDX_W  = $clog2(N_MASK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MASK-1:0] req_i,
  input  logic              nmi_i,
  input  logic              cfg_wr_i,
  input  logic              cfg_sel_i,
  input  logic [N_MASK:0]   cfg_data_i,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              irq_o,
  output logic              vec_valid_o,
  output logic [IDX_W-1:0]  vec_idx_o
);
  localparam int NSRC = N_MASK + 1;

  logic [N_MASK-1:0] en_q, hi_q;
  logic              gen_q;
  logic [NSRC-1:0]   pend, elig, hi_all, win_oh, clr;
  logic [IDX_W-1:0]  win_idx;
  lvl_e              win_lvl, cur_lvl;
  logic              cur_vld, grant;
  logic [N_LVL-1:0]  isr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      gen_q <= 1'b0;
      hi_q  <= '0;
    end else if (cfg_wr_i) begin
      if (cfg_sel_i) hi_q <= cfg_data_i[N_MASK-1:0];
      else begin
        en_q  <= cfg_data_i[N_MASK-1:0];
        gen_q <= cfg_data_i[N_MASK];
      end
    end
  end

  assign elig   = {en_q & {N_MASK{gen_q}}, 1'b1};
  assign hi_all = {hi_q, 1'b0};
  assign grant  = ack_i & irq_o;
  assign clr    = grant ? win_oh : '0;

  nic_pending #(.W(NSRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  ({req_i, nmi_i}),
    .clr_i  (clr),
    .pend_o (pend)
  );

  nic_arbiter #(.N_MASK(N_MASK), .IDX_W(IDX_W)) u_arb (
    .pend_i    (pend),
    .elig_i    (elig),
    .hi_i      (hi_all),
    .cur_vld_i (cur_vld),
    .cur_lvl_i (cur_lvl),
    .irq_o     (irq_o),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl),
    .win_oh_o  (win_oh)
  );

  nic_inservice u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoi_i     (eoi_i),
    .set_i     (grant),
    .set_lvl_i (win_lvl),
    .isr_o     (isr_q),
    .cur_vld_o (cur_vld),
    .cur_lvl_o (cur_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid_o <= 1'b0;
      vec_idx_o   <= '0;
    end else begin
      vec_valid_o <= grant;
      if (grant) vec_idx_o <= win_idx;
    end
  end
endmodule

// File: rtl/nic_chk.sv
module nic_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             irq_o,
  input logic             vec_valid_o,
  input logic [IDX_W-1:0] vec_idx_o,
  input logic [2:0]       isr
);
  // R7
  vec_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> $past(ack_i && irq_o));

  // R10
  idle_ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !eoi_i) |=> (!vec_valid_o && $stable(isr)));

  // R5
  grant_adds_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !eoi_i) |=> ($countones(isr) == $countones($past(isr)) + 1));

  // R6
  eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && isr != 3'b000) |=> ($countones(isr) == $countones($past(isr)) - 1));

  // R2
  top_vec_in_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && vec_idx_o == '0) |-> isr[2]);

  // R11
  ack_eoi_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && eoi_i && $countones(isr) == 1) |=> ($countones(isr) == 1));
endmodule

bind nested_irq_ctrl nic_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ack_i       (ack_i),
  .eoi_i       (eoi_i),
  .irq_o       (irq_o),
  .vec_valid_o (vec_valid_o),
  .vec_idx_o   (vec_idx_o),
  .isr         (isr_q)
);

// File: tb/tb_nested_irq_ctrl.sv
module tb_nested_irq_ctrl;
  localparam int N_MASK = 5;
  localparam int IDX_W  = $clog2(N_MASK + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_MASK-1:0] req_i = '0;
  logic              nmi_i = 1'b0;
  logic              cfg_wr_i = 1'b0;
  logic              cfg_sel_i = 1'b0;
  logic [N_MASK:0]   cfg_data_i = '0;
  logic              ack_i = 1'b0;
  logic              eoi_i = 1'b0;
  logic              irq_o;
  logic              vec_valid_o;
  logic [IDX_W-1:0]  vec_idx_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  nested_irq_ctrl #(.N_MASK(N_MASK)) dut (.*);

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string rq);
    chk(irq_o === e, rq, int'(irq_o), int'(e));
  endtask

  // monitor: every vector must match the next expected one
  always @(negedge clk) begin
    if (rst_n && vec_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected vector", int'(vec_idx_o), -1);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(vec_idx_o) == e, t, int'(vec_idx_o), e);
      end
    end
  end

  task automatic pulse(input logic [N_MASK-1:0] m);
    req_i = m; step(); req_i = '0; step();
  endtask

  task automatic do_ack(input int idx, input string rq);
    exp_q.push_back(idx); tag_q.push_back(rq);
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; step(); eoi_i = 1'b0;
  endtask

  task automatic cfg(input logic sel, input logic [N_MASK:0] d);
    cfg_wr_i = 1'b1; cfg_sel_i = sel; cfg_data_i = d; step(); cfg_wr_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1 reset state; disabled sources stay silent
    chk_irq(1'b0, "R1 irq after reset");
    chk(vec_valid_o === 1'b0, "R1 vec_valid after reset", int'(vec_valid_o), 0);
    pulse(5'b00001);
    chk_irq(1'b0, "R1 sources disabled after reset");

    // R2 unmaskable with every enable clear
    nmi_i = 1'b1; step(); nmi_i = 1'b0; step();
    chk_irq(1'b1, "R2 nmi raises irq");
    do_ack(0, "R2 nmi index");
    do_eoi();

    // enable all; source 0 was pending from the earlier pulse
    cfg(1'b0, 6'b111111);
    do_ack(1, "R9 held pending offered after enable");
    do_eoi();

    // R3 same level fixed order
    pulse(5'b00101);
    chk_irq(1'b1, "R3 irq");
    do_ack(1, "R3 lower position wins");
    step();
    chk_irq(1'b0, "R5 equal level waits");
    do_eoi();
    chk_irq(1'b1, "R8 waiting request offered");
    do_ack(3, "R3 second source");
    do_eoi();

    // R4 high level beats order
    cfg(1'b1, 6'b001000);
    pulse(5'b01001);
    do_ack(4, "R4 high level wins");
    step();
    chk_irq(1'b0, "R5 lower level waits");
    do_eoi();
    do_ack(1, "R4 low source after");
    do_eoi();

    // R5/R6 nesting
    pulse(5'b00010);
    do_ack(2, "R5 low granted");
    pulse(5'b01000);
    chk_irq(1'b1, "R5 higher preempts");
    do_ack(4, "R5 preempting index");
    pulse(5'b10000);
    chk_irq(1'b0, "R8 pulse held while blocked");
    do_eoi();
    chk_irq(1'b0, "R6 low level still active");
    do_eoi();
    chk_irq(1'b1, "R6 offered after both retired");
    do_ack(5, "R8 pulse granted");
    do_eoi();

    // R9 disable while pending, global enable
    pulse(5'b00100);
    cfg(1'b0, 6'b111011);
    chk_irq(1'b0, "R9 disabled source removed");
    cfg(1'b0, 6'b111111);
    chk_irq(1'b1, "R9 re-enabled source back");
    cfg(1'b0, 6'b011111);
    chk_irq(1'b0, "R9 global enable off");
    cfg(1'b0, 6'b111111);
    do_ack(3, "R9 granted after re-enable");
    do_eoi();

    // R10 ack while idle
    ack_i = 1'b1; step(); ack_i = 1'b0; step();
    pulse(5'b00010);
    chk_irq(1'b1, "R10 no level set by idle ack");
    do_ack(2, "R10 follow-up");
    do_eoi();

    // R11 ack and eoi together
    pulse(5'b00001);
    do_ack(1, "R11 low granted");
    pulse(5'b01000);
    exp_q.push_back(4); tag_q.push_back("R11 high granted with eoi");
    ack_i = 1'b1; eoi_i = 1'b1; step(); ack_i = 1'b0; eoi_i = 1'b0;
    pulse(5'b00010);
    chk_irq(1'b0, "R11 high remains in service");
    do_eoi();
    chk_irq(1'b1, "R11 low level was retired");
    do_ack(2, "R11 follow-up");
    do_eoi();

    // R12 edge coinciding with grant
    pulse(5'b00010);
    exp_q.push_back(2); tag_q.push_back("R12 first grant");
    ack_i = 1'b1; req_i = 5'b00010; step(); ack_i = 1'b0; req_i = '0;
    step();
    chk_irq(1'b0, "R12 equal level blocked");
    do_eoi();
    chk_irq(1'b1, "R12 new edge kept");
    do_ack(2, "R12 second grant");
    do_eoi();
    step();
    chk_irq(1'b0, "R7 nothing left pending");
    chk(exp_q.size() == 0, "R7 all vectors seen", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule